// File: doc/BRIEF.md
# Trap and Exception-Return PC Unit

This block holds the program counter and the saved-return-address register of a small 32-bit RISC core, and picks the PC for the next cycle. Each cycle the core presents a valid strobe with three decoded flags: trap, return-from-exception and no-op. It also presents a trap field of the instruction, 26 bits wide, and a sequential next PC that it has already computed.

On a trap, the block jumps to the field zero-extended to 32 bits and used as an absolute address. In the same cycle it saves the address of the trapping instruction plus eight in the return register. On a return-from-exception, the PC is loaded from that register. A no-op, a cycle with no special instruction and a cycle with the strobe low all take the sequential next PC and leave the return register alone.

The PC and the return register are both updated on the same clock edge. An instruction that follows a trap at once therefore sees the new saved value.

Top module: `trap_pc_unit`

## Requirements
- R1: While rstN is low and on the first cycle after it, pc equals the parameter RESET_VEC (default 0x00000100) and iar equals zero.
- R2: After an edge where instValid and isTrap are both 1, pc equals {6'b0, trapField} as sampled at that edge. The field goes to the low 26 bits and the upper 6 bits are zero.
- R3: After the same trap edge, iar equals the previous pc plus 8, modulo 2^32.
- R4: After an edge where instValid and isRfe are 1 and isTrap is 0, pc equals the iar value from before that edge, and iar does not change.
- R5: When isTrap and isRfe are both 1 with instValid, the trap wins and R2 and R3 apply. Both flags win over isNop.
- R6: After an edge where instValid and isNop are 1 and isTrap and isRfe are 0, pc equals seqPc and iar does not change.
- R7: After an edge where instValid is 0, or where it is 1 with all three flags 0, pc equals seqPc and iar does not change. When instValid is 0 the three flags have no effect.
- R8: The iar and pc updates of a trap take effect on the same edge. A return-from-exception in the very next cycle therefore returns to the trapping pc plus 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Qualifies the three class flags |
| isTrap | input | 1 | Instruction is a trap |
| isRfe | input | 1 | Instruction is a return-from-exception |
| isNop | input | 1 | Instruction is a no-op |
| trapField | input | 26 | Absolute trap target field |
| seqPc | input | 32 | Sequential next PC |
| pc | output | 32 | Current program counter |
| iar | output | 32 | Saved return address |

## Verification
The hardest cases to reach are a return that directly follows a trap, and a trap whose saved address wraps past the top of the address space. A return right after a trap shows whether both registers moved on the same edge. The wrap case needs the PC near 0xFFFFFFFC, which only the sequential input can produce. The stimulus first steers the PC there through seqPc, then traps, and then returns in the next cycle. A sweep over all sixteen combinations of strobe and flags, with varied field and seqPc patterns, covers the priority and ignore cases.

// File: rtl/trap_pc_pkg.sv
package trap_pc_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_TRAP = 2'd1,
    SEL_RFE  = 2'd2
  } pcSelT;

  typedef struct packed {
    pcSelT pcSel;
    logic  loadIar;
  } ctrlT;
endpackage

// File: rtl/trap_pc_ctrl.sv
module trap_pc_ctrl
  import trap_pc_pkg::*;
(
  input  logic instValid,
  input  logic isTrap,
  input  logic isRfe,
  input  logic isNop,
  output ctrlT ctrl
);
  always_comb begin
    ctrl.pcSel   = SEL_SEQ;
    ctrl.loadIar = 1'b0;
    if (instValid) begin
      if (isTrap) begin
        ctrl.pcSel   = SEL_TRAP;
        ctrl.loadIar = 1'b1;
      end else if (isRfe) begin
        ctrl.pcSel = SEL_RFE;
      end else if (isNop) begin
        ctrl.pcSel = SEL_SEQ;
      end
    end
  end
endmodule

// File: rtl/trap_pc_dp.sv
module trap_pc_dp
  import trap_pc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          FIELD_W    = 26,
  parameter int          RET_OFFSET = 8,
  parameter logic [31:0] RESET_VEC  = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlT               ctrl,
  input  logic [FIELD_W-1:0] trapField,
  input  logic [XLEN-1:0]    seqPc,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    iar
);
  localparam int PAD_W = XLEN - FIELD_W;

  logic [XLEN-1:0] pcReg, iarReg, trapTarget, retAddr, pcNext;

  assign trapTarget = {{PAD_W{1'b0}}, trapField};
  assign retAddr    = pcReg + XLEN'(RET_OFFSET);

  always_comb begin
    unique case (ctrl.pcSel)
      SEL_TRAP: pcNext = trapTarget;
      SEL_RFE:  pcNext = iarReg;
      default:  pcNext = seqPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg  <= RESET_VEC[XLEN-1:0];
      iarReg <= '0;
    end else begin
      pcReg <= pcNext;
      if (ctrl.loadIar) iarReg <= retAddr;
    end
  end

  assign pc  = pcReg;
  assign iar = iarReg;
endmodule

// File: rtl/trap_pc_unit.sv
module trap_pc_unit
  import trap_pc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          FIELD_W    = 26,
  parameter int          RET_OFFSET = 8,
  parameter logic [31:0] RESET_VEC  = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic               isTrap,
  input  logic               isRfe,
  input  logic               isNop,
  input  logic [FIELD_W-1:0] trapField,
  input  logic [XLEN-1:0]    seqPc,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    iar
);
  ctrlT ctrl;

  trap_pc_ctrl uCtrl (
    .instValid(instValid),
    .isTrap   (isTrap),
    .isRfe    (isRfe),
    .isNop    (isNop),
    .ctrl     (ctrl)
  );

  trap_pc_dp #(
    .XLEN      (XLEN),
    .FIELD_W   (FIELD_W),
    .RET_OFFSET(RET_OFFSET),
    .RESET_VEC (RESET_VEC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .trapField(trapField),
    .seqPc    (seqPc),
    .pc       (pc),
    .iar      (iar)
  );
endmodule

// File: rtl/trap_pc_checker.sv
module trap_pc_checker #(
  parameter int XLEN       = 32,
  parameter int FIELD_W    = 26,
  parameter int RET_OFFSET = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               instValid,
  input logic               isTrap,
  input logic               isRfe,
  input logic [FIELD_W-1:0] trapField,
  input logic [XLEN-1:0]    seqPc,
  input logic [XLEN-1:0]    pc,
  input logic [XLEN-1:0]    iar
);
  logic started;
  always_ff @(posedge clk) started <= rstN;

  // R2 and R5: trap target is the zero-extended field
  a_r2_trap_target: assert property (@(posedge clk) disable iff (!rstN || !started)
    (instValid && isTrap) |=> (pc == XLEN'($past(trapField))));

  // R3 and R8: return address is saved on the same edge
  a_r3_trap_iar: assert property (@(posedge clk) disable iff (!rstN || !started)
    (instValid && isTrap) |=> (iar == $past(pc) + XLEN'(RET_OFFSET)));

  // R4: return-from-exception restores the PC
  a_r4_rfe_restore: assert property (@(posedge clk) disable iff (!rstN || !started)
    (instValid && isRfe && !isTrap) |=> (pc == $past(iar)));

  // R4, R6, R7: the return register is held when no trap occurs
  a_r6_iar_hold: assert property (@(posedge clk) disable iff (!rstN || !started)
    !(instValid && isTrap) |=> $stable(iar));

  // R7: sequential flow otherwise
  a_r7_seq_flow: assert property (@(posedge clk) disable iff (!rstN || !started)
    !(instValid && (isTrap || isRfe)) |=> (pc == $past(seqPc)));
endmodule

bind trap_pc_unit trap_pc_checker #(
  .XLEN(XLEN), .FIELD_W(FIELD_W), .RET_OFFSET(RET_OFFSET)
) uChecker (
  .clk(clk), .rstN(rstN), .instValid(instValid), .isTrap(isTrap),
  .isRfe(isRfe), .trapField(trapField), .seqPc(seqPc), .pc(pc), .iar(iar)
);

// File: tb/trap_pc_unit_test.sv
module trap_pc_unit_test;
  localparam logic [31:0] RST_VEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0, isTrap = 1'b0, isRfe = 1'b0, isNop = 1'b0;
  logic [25:0] trapField = '0;
  logic [31:0] seqPc = '0;
  logic [31:0] pc, iar;
  logic [31:0] expPc, expIar;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trap_pc_unit #(.RESET_VEC(RST_VEC)) uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .isTrap(isTrap),
    .isRfe(isRfe), .isNop(isNop), .trapField(trapField), .seqPc(seqPc),
    .pc(pc), .iar(iar)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic t, input logic r,
                      input logic n, input logic [25:0] f, input logic [31:0] s);
    string tag;
    logic [31:0] nPc, nIar;
    @(negedge clk);
    instValid = v; isTrap = t; isRfe = r; isNop = n; trapField = f; seqPc = s;
    nIar = expIar;
    if (!v) begin tag = "R7"; nPc = s; end
    else if (t) begin
      tag = r ? "R5" : "R2/R3";
      nPc = {6'b0, f};
      nIar = expPc + 32'd8;
    end
    else if (r) begin tag = "R4"; nPc = expIar; end
    else if (n) begin tag = "R6"; nPc = s; end
    else begin tag = "R7"; nPc = s; end
    @(posedge clk); #1;
    expPc = nPc; expIar = nIar;
    check(tag, "pc", pc, expPc);
    check(tag, "iar", iar, expIar);
  endtask

  initial begin
    expPc = RST_VEC; expIar = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "pc in reset", pc, RST_VEC);
    check("R1", "iar in reset", iar, 32'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    // first edge after release: idle inputs, pc takes seqPc = 0
    expPc = 32'd0;
    check("R1", "iar after reset", iar, 32'd0);
    check("R7", "pc after reset", pc, expPc);

    // full sweep of strobe and flags with varied data
    for (int k = 0; k < 256; k++) begin
      logic [3:0]  combo = k[3:0];
      logic [25:0] f = (k[5:4] == 2'd0) ? 26'h3FF_FFFF :
                       (k[5:4] == 2'd1) ? 26'd0 : 26'(k * 32'h0001_3579);
      logic [31:0] s = 32'hF000_0000 ^ (k * 32'h0101_0104);
      step(combo[3], combo[2], combo[1], combo[0], f, s);
    end

    // R3 wrap: pc at 0xFFFFFFFC, trap saves 4
    step(1'b0, 1'b0, 1'b0, 1'b0, 26'd0, 32'hFFFF_FFFC);
    step(1'b1, 1'b1, 1'b0, 1'b0, 26'h200_0000, 32'h0);
    check("R3", "wrapped return address", iar, 32'h0000_0004);
    check("R2", "upper field bit zero-extended", pc, 32'h0200_0000);
    // R8: immediate return after trap lands on trapping pc + 8
    step(1'b1, 1'b0, 1'b1, 1'b0, 26'd0, 32'h1234_5678);
    check("R8", "return right after trap", pc, 32'h0000_0004);
    // trap followed by trap overwrites, then return
    step(1'b1, 1'b1, 1'b0, 1'b0, 26'h000_1000, 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 26'h000_2000, 32'h0);
    check("R3", "second trap overwrites iar", iar, 32'h0000_1008);
    step(1'b1, 1'b0, 1'b1, 1'b1, 26'd0, 32'h0);
    check("R5", "return beats no-op", pc, 32'h0000_1008);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule